// File: doc/BRIEF.md
# Word FIFO Pair with Byte Packing

This block holds a transmit queue and a receive queue of 32-bit words behind a small word-addressed register port. Software loads outgoing payload words into the transmit queue and takes incoming words from the receive queue. A byte-stream port on the far side feeds a bus engine one byte at a time. That engine drains bytes from the transmit words and returns bytes that are packed into receive words. Bytes travel in little-endian lane order: the first byte of a word is bits 7:0.

A control register holds one self-clearing flush bit and one trigger threshold for each direction. A status register reports how many transmit slots are free and how many receive words are waiting. Two level outputs request service when an occupancy crosses its threshold. Two sticky flags record a write into a full transmit queue and a read from an empty receive queue. Both flags are meant for an interrupt collector outside the block.

Two length registers set the byte count of the current transfer in each direction. When that count is not a multiple of four, the last word holds only the low 1 to 3 lanes.

Top module: `wordq_pair`

## Requirements
- R1: After reset, the status word reads 0x080 (8 free transmit slots, 0 receive words), the control word reads 0, both flags are low and no byte is offered.
- R2: The registers sit at word addresses 0 control, 1 status, 2 transmit data (write), 3 receive data (read), 4 transmit length and 5 receive length. Status bits 3:0 give the receive words held and bits 7:4 give the free transmit slots. Each queue holds 8 words in first-in first-out order.
- R3: A write to transmit data while 8 words are held is dropped. It sets `tx_ovf`, also shown in status bit 8, and the flag stays set until a transmit flush.
- R4: A read of receive data while the queue is empty returns 0. It sets `rx_unf`, also shown in status bit 9, and the flag stays set until a receive flush.
- R5: Writing 1 to control bit 1 (transmit) or bit 0 (receive) flushes that direction. The bit reads back as 1 in the following cycle and as 0 after that. The flush empties the queue, zeroes its remaining length and partial lane state, and clears its flag. The other direction is left untouched.
- R6: Control bits 7:5 hold the transmit trigger and bits 4:2 hold the receive trigger. `tx_req` is high while free slots are at least the trigger plus one. `rx_req` is high while held words exceed the trigger. The setting transmit 7, receive 0 is valid.
- R7: Transmit bytes leave the oldest word in lane order 7:0, 15:8, 23:16, 31:24. The word is removed after its fourth byte is accepted.
- R8: When the remaining transmit length is not a multiple of four, only the low lanes of the last word are sent. That word is then removed, and `tx_byte_valid` stays low once the length reaches zero.
- R9: Receive bytes are placed in lanes 7:0 upward, and a word is queued after its fourth byte. `rx_byte_ready` is low while the receive queue is full or the length is zero.
- R10: A final receive word holding 1 to 3 bytes is queued right after its last byte, with its unused upper lanes zero.
- R11: Writing a length register loads the byte count from bits 12:0. Reading it back returns the bytes still to move, which drop by one per accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a receive data read pops a word) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register, same cycle |
| tx_byte_valid | output | 1 | A transmit byte is offered |
| tx_byte | output | 8 | Offered transmit byte |
| tx_byte_ready | input | 1 | Bus engine takes the offered byte |
| rx_byte_valid | input | 1 | Bus engine offers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_byte_ready | output | 1 | Block accepts the received byte |
| tx_req | output | 1 | Transmit free space above the trigger |
| rx_req | output | 1 | Receive fill above the trigger |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_unf | output | 1 | Sticky receive underflow flag |

## Verification
Register writes and byte handshakes take effect at the rising edge that samples them. Status, flags, the data requests and the byte-port outputs show the new value in the same cycle that follows that edge. A flush bit shows as 1 for exactly one cycle and the queue reads empty one edge later. Read data is combinational from the addressed register. The bench holds a behavioural model with queues that advances at each rising edge from the same inputs. Every cycle, 2 ns after the falling edge, it compares every output with that model, so each result is checked in the first cycle it is due.

// File: rtl/wq_pkg.sv
package wq_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int ADDR_W = 3;
  localparam int TRIG_W = 3;
  localparam int STAT_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TXD   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RXD   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TXLEN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RXLEN = ADDR_W'(5);

  localparam int CTL_RXFL   = 0;
  localparam int CTL_TXFL   = 1;
  localparam int CTL_RXTRIG = 2;
  localparam int CTL_TXTRIG = 5;

  localparam int ST_RXCNT  = 0;
  localparam int ST_TXFREE = 4;
  localparam int ST_OVF    = 8;
  localparam int ST_UNF    = 9;

  // write one byte into lane i of a word
  function automatic logic [WORD_W-1:0] lane_put(input logic [WORD_W-1:0] w,
                                                 input logic [LANE_W-1:0] i,
                                                 input logic [7:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    r[8*i +: 8] = b;
    return r;
  endfunction

  // pick lane i of a word
  function automatic logic [7:0] lane_get(input logic [WORD_W-1:0] w,
                                          input logic [LANE_W-1:0] i);
    return w[8*i +: 8];
  endfunction

  // word boundary reached: top lane, or the transfer's final byte
  function automatic logic lane_last(input logic [LANE_W-1:0] i,
                                     input logic one_left);
    return (i == LANE_W'(LANES - 1)) || one_left;
  endfunction

  // service request rule shared by both directions
  function automatic logic level_above(input logic [7:0] lvl,
                                       input logic [7:0] trig);
    return lvl > trig;
  endfunction

  // saturating status field
  function automatic logic [STAT_W-1:0] stat_field(input logic [7:0] n);
    return (n > 8'((1 << STAT_W) - 1)) ? '1 : n[STAT_W-1:0];
  endfunction
endpackage

// File: rtl/wq_fifo.sv
module wq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       push_drop,
  output logic                       pop_miss
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign pop_miss  = pop && empty && !flush;
  assign head      = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[g] <= '0;
        else if (push_ok && wr_ptr == PTR_W'(g))
          mem[g] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/wq_unpack.sv
module wq_unpack
  import wq_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              word_avail,
  input  logic [WORD_W-1:0] head_word,
  input  logic              byte_ready,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  output logic              word_pop,
  output logic [LEN_W-1:0]  rem
);
  logic [LANE_W-1:0] idx;
  logic              fire, last;

  assign byte_valid = !flush && (rem != '0) && word_avail;
  assign byte_data  = lane_get(head_word, idx);
  assign fire       = byte_valid && byte_ready;
  assign last       = lane_last(idx, rem == LEN_W'(1));
  assign word_pop   = fire && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      idx <= '0;
    end else if (flush) begin
      rem <= '0;
      idx <= '0;
    end else if (len_wr) begin
      rem <= len_val;
      idx <= '0;
    end else if (fire) begin
      rem <= rem - LEN_W'(1);
      idx <= last ? '0 : idx + LANE_W'(1);
    end
  end
endmodule

// File: rtl/wq_pack.sv
module wq_pack
  import wq_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_val,
  input  logic              space,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              byte_ready,
  output logic              word_push,
  output logic [WORD_W-1:0] word_data,
  output logic [LEN_W-1:0]  rem
);
  logic [LANE_W-1:0] idx;
  logic [WORD_W-1:0] acc;
  logic              fire, last;

  assign byte_ready = !flush && (rem != '0) && space;
  assign fire       = byte_valid && byte_ready;
  assign last       = lane_last(idx, rem == LEN_W'(1));
  assign word_data  = lane_put(acc, idx, byte_data);
  assign word_push  = fire && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0;
      idx <= '0;
      acc <= '0;
    end else if (flush) begin
      rem <= '0;
      idx <= '0;
      acc <= '0;
    end else if (len_wr) begin
      rem <= len_val;
      idx <= '0;
      acc <= '0;
    end else if (fire) begin
      rem <= rem - LEN_W'(1);
      idx <= last ? '0 : idx + LANE_W'(1);
      acc <= last ? '0 : word_data;
    end
  end
endmodule

// File: rtl/wordq_pair.sv
module wordq_pair
  import wq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_byte_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_byte_ready,
  input  logic              rx_byte_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_byte_ready,
  output logic              tx_req,
  output logic              rx_req,
  output logic              tx_ovf,
  output logic              rx_unf
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // register decode
  logic ctl_wr, txd_wr, rxd_rd, txlen_wr, rxlen_wr;
  assign ctl_wr   = reg_wr && (reg_addr == A_CTRL);
  assign txd_wr   = reg_wr && (reg_addr == A_TXD);
  assign txlen_wr = reg_wr && (reg_addr == A_TXLEN);
  assign rxlen_wr = reg_wr && (reg_addr == A_RXLEN);
  assign rxd_rd   = reg_rd && (reg_addr == A_RXD);

  // control state
  logic [TRIG_W-1:0] tx_trig, rx_trig;
  logic              tx_fl, rx_fl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_trig <= '0;
      rx_trig <= '0;
      tx_fl   <= 1'b0;
      rx_fl   <= 1'b0;
    end else if (ctl_wr) begin
      tx_trig <= reg_wdata[CTL_TXTRIG +: TRIG_W];
      rx_trig <= reg_wdata[CTL_RXTRIG +: TRIG_W];
      tx_fl   <= reg_wdata[CTL_TXFL];
      rx_fl   <= reg_wdata[CTL_RXFL];
    end else begin
      tx_fl   <= 1'b0;
      rx_fl   <= 1'b0;
    end
  end

  // transmit path: register writes in, byte lanes out
  logic [WORD_W-1:0] tx_head;
  logic [CNT_W-1:0]  tx_cnt, tx_free;
  logic              tx_full, tx_empty, tx_pop, tx_drop, tx_miss;
  logic [LEN_W-1:0]  tx_rem;

  wq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_fl),
    .push(txd_wr), .wdata(reg_wdata), .pop(tx_pop),
    .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .push_drop(tx_drop), .pop_miss(tx_miss)
  );

  wq_unpack #(.LEN_W(LEN_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .flush(tx_fl),
    .len_wr(txlen_wr), .len_val(reg_wdata[LEN_W-1:0]),
    .word_avail(!tx_empty), .head_word(tx_head),
    .byte_ready(tx_byte_ready), .byte_valid(tx_byte_valid),
    .byte_data(tx_byte), .word_pop(tx_pop), .rem(tx_rem)
  );

  // receive path: byte lanes in, register reads out
  logic [WORD_W-1:0] rx_head, rx_word;
  logic [CNT_W-1:0]  rx_cnt;
  logic              rx_full, rx_empty, rx_push, rx_drop, rx_miss;
  logic [LEN_W-1:0]  rx_rem;

  wq_pack #(.LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .flush(rx_fl),
    .len_wr(rxlen_wr), .len_val(reg_wdata[LEN_W-1:0]),
    .space(!rx_full), .byte_valid(rx_byte_valid), .byte_data(rx_byte),
    .byte_ready(rx_byte_ready), .word_push(rx_push),
    .word_data(rx_word), .rem(rx_rem)
  );

  wq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_fl),
    .push(rx_push), .wdata(rx_word), .pop(rxd_rd),
    .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .push_drop(rx_drop), .pop_miss(rx_miss)
  );

  // sticky error flags, cleared by the matching flush
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      rx_unf <= 1'b0;
    end else begin
      if (tx_fl)        tx_ovf <= 1'b0;
      else if (tx_drop) tx_ovf <= 1'b1;
      if (rx_fl)        rx_unf <= 1'b0;
      else if (rx_miss) rx_unf <= 1'b1;
    end
  end

  // occupancy and service requests
  assign tx_free = CNT_W'(DEPTH) - tx_cnt;
  assign tx_req  = level_above(8'(tx_free), 8'(tx_trig));
  assign rx_req  = level_above(8'(rx_cnt), 8'(rx_trig));

  logic [31:0] ctl_word, stat_word;
  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_TXTRIG +: TRIG_W] = tx_trig;
    ctl_word[CTL_RXTRIG +: TRIG_W] = rx_trig;
    ctl_word[CTL_TXFL] = tx_fl;
    ctl_word[CTL_RXFL] = rx_fl;
    stat_word = '0;
    stat_word[ST_RXCNT  +: STAT_W] = stat_field(8'(rx_cnt));
    stat_word[ST_TXFREE +: STAT_W] = stat_field(8'(tx_free));
    stat_word[ST_OVF] = tx_ovf;
    stat_word[ST_UNF] = rx_unf;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctl_word;
      A_STAT:  reg_rdata = stat_word;
      A_RXD:   reg_rdata = rx_empty ? '0 : rx_head;
      A_TXLEN: reg_rdata = 32'(tx_rem);
      A_RXLEN: reg_rdata = 32'(rx_rem);
      default: reg_rdata = '0;
    endcase
  end

  // a push into the receive queue is never refused: ready covers space
  logic unused_ok;
  assign unused_ok = rx_drop | tx_miss | (|tx_full);
endmodule

// File: rtl/wq_chk.sv
module wq_chk #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 13,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             txd_wr,
  input logic             rxd_rd,
  input logic             txlen_wr,
  input logic             rxlen_wr,
  input logic             tx_fl,
  input logic             rx_fl,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [LEN_W-1:0] tx_rem,
  input logic [LEN_W-1:0] rx_rem,
  input logic             tx_byte_valid,
  input logic             tx_byte_ready,
  input logic             rx_byte_valid,
  input logic             rx_byte_ready,
  input logic             tx_req,
  input logic             rx_req,
  input logic             tx_ovf,
  input logic             rx_unf
);
  a_r5_tx_flush_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fl && !ctl_wr) |=> (tx_cnt == '0 && !tx_fl && tx_rem == '0 && !tx_ovf));

  a_r5_rx_flush_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fl && !ctl_wr) |=> (rx_cnt == '0 && !rx_fl && rx_rem == '0 && !rx_unf));

  a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH));

  a_r2_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH));

  a_r6_empty_tx_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0) |-> tx_req);

  a_r6_empty_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '0) |-> !rx_req);

  a_r3_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && tx_cnt == CNT_W'(DEPTH) && !tx_fl) |=> tx_ovf);

  a_r4_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_rd && rx_cnt == '0 && !rx_fl) |=> rx_unf);

  a_r8_last_byte_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_byte_valid && tx_byte_ready && tx_rem == LEN_W'(1) && !txlen_wr)
      |=> !tx_byte_valid);

  a_r10_tail_pushed: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_valid && rx_byte_ready && rx_rem == LEN_W'(1) && !rxd_rd && !rxlen_wr)
      |=> (rx_cnt == $past(rx_cnt) + CNT_W'(1)));
endmodule

bind wordq_pair wq_chk #(
  .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W($clog2(DEPTH + 1))
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .ctl_wr(ctl_wr), .txd_wr(txd_wr), .rxd_rd(rxd_rd),
  .txlen_wr(txlen_wr), .rxlen_wr(rxlen_wr),
  .tx_fl(tx_fl), .rx_fl(rx_fl),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_rem(tx_rem), .rx_rem(rx_rem),
  .tx_byte_valid(tx_byte_valid), .tx_byte_ready(tx_byte_ready),
  .rx_byte_valid(rx_byte_valid), .rx_byte_ready(rx_byte_ready),
  .tx_req(tx_req), .rx_req(rx_req),
  .tx_ovf(tx_ovf), .rx_unf(rx_unf)
);

// File: tb/wordq_pair_tb_top.sv
module wordq_pair_tb_top;
  localparam int DEPTH = 8;
  localparam int LEN_W = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_byte_valid, rx_byte_ready, tx_req, rx_req, tx_ovf, rx_unf;
  logic [7:0]  tx_byte;
  logic        tx_byte_ready = 1'b0, rx_byte_valid = 1'b0;
  logic [7:0]  rx_byte = '0;

  always #10 clk = ~clk;

  wordq_pair #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte), .tx_byte_ready(tx_byte_ready),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_byte_ready(rx_byte_ready),
    .tx_req(tx_req), .rx_req(rx_req), .tx_ovf(tx_ovf), .rx_unf(rx_unf)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] last_rd;

  // behavioural reference model
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  int          m_trem = 0, m_tidx = 0, m_rrem = 0, m_ridx = 0;
  logic [31:0] m_acc = '0;
  logic [2:0]  m_ttrig = '0, m_rtrig = '0;
  bit          m_txfl = 0, m_rxfl = 0, m_ovf = 0, m_unf = 0;

  always @(posedge clk) begin
    int tsz, rsz;
    bit tf, rf;
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_trem = 0; m_tidx = 0; m_rrem = 0; m_ridx = 0; m_acc = '0;
      m_ttrig = '0; m_rtrig = '0; m_txfl = 0; m_rxfl = 0; m_ovf = 0; m_unf = 0;
    end else begin
      tsz = txq.size();
      rsz = rxq.size();
      tf = !m_txfl && m_trem != 0 && tsz != 0 && tx_byte_ready;
      rf = !m_rxfl && m_rrem != 0 && rsz < DEPTH && rx_byte_valid;
      if (m_txfl) begin
        txq.delete(); m_trem = 0; m_tidx = 0; m_ovf = 0;
      end else begin
        if (tf) begin
          if (m_tidx == 3 || m_trem == 1) begin void'(txq.pop_front()); m_tidx = 0; end
          else m_tidx++;
          m_trem--;
        end
        if (reg_wr && reg_addr == 3'd2) begin
          if (tsz < DEPTH) txq.push_back(reg_wdata); else m_ovf = 1;
        end
        if (reg_wr && reg_addr == 3'd4) begin m_trem = int'(reg_wdata[LEN_W-1:0]); m_tidx = 0; end
      end
      if (m_rxfl) begin
        rxq.delete(); m_rrem = 0; m_ridx = 0; m_acc = '0; m_unf = 0;
      end else begin
        if (reg_rd && reg_addr == 3'd3) begin
          if (rsz > 0) void'(rxq.pop_front()); else m_unf = 1;
        end
        if (rf) begin
          m_acc[8*m_ridx +: 8] = rx_byte;
          if (m_ridx == 3 || m_rrem == 1) begin rxq.push_back(m_acc); m_acc = '0; m_ridx = 0; end
          else m_ridx++;
          m_rrem--;
        end
        if (reg_wr && reg_addr == 3'd5) begin
          m_rrem = int'(reg_wdata[LEN_W-1:0]); m_ridx = 0; m_acc = '0;
        end
      end
      if (reg_wr && reg_addr == 3'd0) begin
        m_ttrig = reg_wdata[7:5]; m_rtrig = reg_wdata[4:2];
        m_txfl = reg_wdata[1]; m_rxfl = reg_wdata[0];
      end else begin
        m_txfl = 0; m_rxfl = 0;
      end
    end
  end

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rdata();
    int tsz = txq.size();
    int rsz = rxq.size();
    case (reg_addr)
      3'd0: return {24'd0, m_ttrig, m_rtrig, m_txfl, m_rxfl};
      3'd1: return {22'd0, m_unf, m_ovf, 4'(DEPTH - tsz), 4'(rsz)};
      3'd3: return (rsz > 0) ? rxq[0] : 32'd0;
      3'd4: return 32'(m_trem);
      3'd5: return 32'(m_rrem);
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare();
    int tsz = txq.size();
    int rsz = rxq.size();
    bit ev;
    check_eq("R6", "tx_req", 32'(tx_req), 32'((DEPTH - tsz) > int'(m_ttrig)));
    check_eq("R6", "rx_req", 32'(rx_req), 32'(rsz > int'(m_rtrig)));
    ev = !m_txfl && m_trem != 0 && tsz != 0;
    check_eq("R8", "tx_byte_valid", 32'(tx_byte_valid), 32'(ev));
    if (ev) check_eq("R7", "tx_byte", 32'(tx_byte), 32'(8'(txq[0] >> (8*m_tidx))));
    check_eq("R9", "rx_byte_ready", 32'(rx_byte_ready),
             32'(!m_rxfl && m_rrem != 0 && rsz < DEPTH));
    check_eq("R3", "tx_ovf", 32'(tx_ovf), 32'(m_ovf));
    check_eq("R4", "rx_unf", 32'(rx_unf), 32'(m_unf));
    if (reg_rd) check_eq("R2", "reg_rdata", reg_rdata, model_rdata());
  endtask

  task automatic cyc();
    #2;
    last_rd = reg_rdata;
    compare();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    cyc();
    reg_rd = 1'b0;
    d = last_rd;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  got[$];
    int          k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd1, v); check_eq("R1", "status after reset", v, 32'h080);
    rd(3'd0, v); check_eq("R1", "control after reset", v, 32'h0);
    check_eq("R1", "flags after reset", {30'd0, tx_ovf, rx_unf}, 32'h0);
    check_eq("R1", "no byte offered", 32'(tx_byte_valid), 32'h0);

    // R6 trigger setting tx 7 rx 0
    wr(3'd0, 32'hE0);
    check_eq("R6", "tx_req empty trig7", 32'(tx_req), 32'h1);
    wr(3'd2, 32'h44332211);
    check_eq("R6", "tx_req 7 free trig7", 32'(tx_req), 32'h0);
    rd(3'd1, v); check_eq("R2", "status one word", v, 32'h070);

    // R3 overflow
    for (int i = 0; i < 7; i++) wr(3'd2, 32'h1000 + i);
    rd(3'd1, v); check_eq("R2", "status tx full", v, 32'h000);
    wr(3'd2, 32'hDEAD);
    rd(3'd1, v); check_eq("R3", "status overflow", v, 32'h100);
    check_eq("R3", "tx_ovf port", 32'(tx_ovf), 32'h1);

    // R5 transmit flush
    wr(3'd0, 32'hE2);
    rd(3'd0, v); check_eq("R5", "flush bit visible", v, 32'hE2);
    rd(3'd0, v); check_eq("R5", "flush bit cleared", v, 32'hE0);
    rd(3'd1, v); check_eq("R5", "tx emptied, flag cleared", v, 32'h080);

    // R7 R8 byte unpacking with partial last word
    wr(3'd4, 32'd6);
    wr(3'd2, 32'h44332211);
    wr(3'd2, 32'h88776655);
    for (int i = 0; i < 20; i++) begin
      tx_byte_ready = (i % 3 != 1);
      #2;
      if (tx_byte_valid && tx_byte_ready) got.push_back(tx_byte);
      last_rd = reg_rdata;
      compare();
      @(negedge clk);
    end
    tx_byte_ready = 1'b0;
    check_eq("R8", "bytes sent", 32'(got.size()), 32'd6);
    for (int i = 0; i < 6 && i < got.size(); i++)
      check_eq("R7", "byte order", 32'(got[i]), 32'(8'h11 * (i + 1)));
    rd(3'd1, v); check_eq("R8", "partial word removed", v, 32'h080);
    rd(3'd4, v); check_eq("R11", "tx length drained", v, 32'd0);
    check_eq("R8", "valid low after length", 32'(tx_byte_valid), 32'h0);

    // R9 R10 R11 packing
    wr(3'd5, 32'd7);
    rd(3'd5, v); check_eq("R11", "rx length loaded", v, 32'd7);
    k = 0;
    for (int i = 0; i < 30 && k < 7; i++) begin
      bit fire;
      rx_byte_valid = (i % 4 != 2);
      rx_byte = 8'hA0 + 8'(k);
      #2;
      fire = rx_byte_valid && rx_byte_ready;
      last_rd = reg_rdata;
      compare();
      @(negedge clk);
      if (fire) k++;
      if (i == 2) begin
        rx_byte_valid = 1'b0;
        rd(3'd5, v); check_eq("R11", "rx length counts down", v, 32'(7 - k));
      end
    end
    rx_byte_valid = 1'b0;
    rd(3'd5, v); check_eq("R11", "rx length drained", v, 32'd0);
    rd(3'd1, v); check_eq("R9", "two words queued", v, 32'h082);
    rd(3'd3, v); check_eq("R9", "full word lanes", v, 32'hA3A2A1A0);
    rd(3'd3, v); check_eq("R10", "partial word zero filled", v, 32'h00A6A5A4);

    // R4 underflow and selective R5 receive flush
    wr(3'd2, 32'h5555);
    rd(3'd3, v); check_eq("R4", "empty read returns 0", v, 32'h0);
    check_eq("R4", "rx_unf port", 32'(rx_unf), 32'h1);
    rd(3'd1, v); check_eq("R4", "status underflow", v, 32'h270);
    wr(3'd0, 32'hE1);
    cyc();
    rd(3'd1, v); check_eq("R5", "rx flush keeps tx word", v, 32'h070);
    wr(3'd0, 32'hE2);
    cyc();

    // R9 back-pressure and R6 receive trigger
    wr(3'd0, 32'h0C);
    wr(3'd5, 32'd40);
    rx_byte_valid = 1'b1;
    for (int i = 0; i < 45; i++) begin
      rx_byte = 8'(i);
      cyc();
    end
    check_eq("R9", "ready low when full", 32'(rx_byte_ready), 32'h0);
    rx_byte_valid = 1'b0;
    rd(3'd1, v); check_eq("R2", "rx full status", v, 32'h088);
    check_eq("R6", "rx_req over trig3", 32'(rx_req), 32'h1);
    rd(3'd3, v); check_eq("R9", "first packed word", v, 32'h03020100);
    for (int i = 0; i < 4; i++) rd(3'd3, v);
    check_eq("R6", "rx_req at trig3", 32'(rx_req), 32'h0);

    // R5 receive flush mid-word
    rx_byte_valid = 1'b1;
    cyc(); cyc();
    rx_byte_valid = 1'b0;
    wr(3'd0, 32'h0D);
    cyc();
    rd(3'd5, v); check_eq("R5", "rx length zeroed", v, 32'd0);
    rd(3'd1, v); check_eq("R5", "rx emptied", v, 32'h080);
    check_eq("R5", "ready low after flush", 32'(rx_byte_ready), 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule